// File: doc/BRIEF.md
# Vedic Decimal Division Iteration Engine

This block divides an unsigned decimal dividend, given as packed BCD digits, by a divisor that arrives in two forms: its plain BCD digits and a signed-digit "adjusted" form in which every digit lies between -5 and 5 and the whole string is negated, so that its weighted sum equals minus the divisor. The divider never tries a subtraction for each quotient bit. Each step reads the leading digit of the remainder magnitude. When that digit is smaller than the leading divisor magnitude, it reads the two leading digits together. It divides this value by the leading divisor magnitude (always 1 to 5) through a small lookup, which gives a quotient digit. It then adds that digit times every adjusted digit into the aligned remainder positions, folds the positions back into decimal digits, and adds the digit into the quotient at the same offset.

The remainder is kept as a sign and a BCD magnitude, so an estimate that overshoots simply makes the next quotient digit negative. When no aligned step is left, a short correction phase runs. It adds the divisor back while the remainder is negative, and removes one more divisor while the remainder is still at least the plain divisor. Each correction moves the quotient by one. The user pulses `start` with stable operands and reads the results while `done` is high.

Top module: `vdiv_top`

## Requirements
- R1: After reset, `busy` and `done` are low and both result buses read zero.
- R2: A `start` pulse seen while not busy captures all three operands. `busy` is high and `done` is low in the following cycle.
- R3: Operand digit i of a BCD bus occupies bits [4i+3:4i]. Adjusted digit i is a 5-bit two's complement value at bits [5i+4:5i] with i from 0 to DIGITS. The sum of digit i times 10^i equals minus the divisor, the highest nonzero digit is in -5..-1, and the other digits are in -5..5.
- R4: A step's quotient digit is the floor of the leading remainder value divided by the leading divisor magnitude. The leading value is one digit, or two digits combined when the top digit is smaller than that magnitude. The digit is always in 1..9.
- R5: A step adds the signed quotient digit times each adjusted digit into the remainder positions shifted by the step offset. It adds the same signed digit to the quotient at that offset. Carries and borrows then run upward from the least significant position, leaving every stored digit in 0..9 plus a sign.
- R6: Aligned steps stop as soon as the remainder is zero or the step offset would fall below zero.
- R7: In the correction phase, a negative remainder gets the divisor added and the quotient lowered by one. A non-negative remainder that is at least the plain divisor gets the divisor removed and the quotient raised by one. The phase repeats until neither holds.
- R8: When `done` rises, the quotient equals floor(dividend / divisor) and the remainder equals dividend mod divisor, for any dividend below 10^DIGITS and any divisor from 1 to 10^DIGITS - 1.
- R9: `done` and the results hold until the next accepted `start`. A `start` while busy is ignored and does not disturb the running division.
- R10: A dividend smaller than the divisor, including zero, yields quotient zero and the dividend as remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division with the current operands |
| dividendBcd | input | 4*DIGITS | Dividend, packed BCD |
| adjDivisor | input | 5*(DIGITS+1) | Negated signed-digit divisor, 5-bit digits |
| origDivisorBcd | input | 4*DIGITS | Divisor, packed BCD |
| quotientBcd | output | 4*DIGITS | Quotient, packed BCD |
| remainderBcd | output | 4*DIGITS | Remainder, packed BCD |
| busy | output | 1 | Division in progress |
| done | output | 1 | Results valid |

## Verification
The hardest state to reach from the ports is a negative remainder entering the correction phase, and, next to it, a non-negative remainder that still needs a second removal of the divisor. Both occur only when the adjusted divisor's lower digits pull the true divisor far from its leading digit times a power of ten. The stimulus therefore includes divisors such as 15, 6, 1555 and 45454545, whose adjusted forms have large signed tails. It also runs a long random sweep with divisor lengths drawn from 1 to 8 digits, so that every leading magnitude and both kinds of overshoot come up many times.

// File: rtl/vdiv_pkg.sv
package vdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2,
    ST_DONE = 2'd3
  } vdivState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
    logic fix;
  } vdivCtrl_t;

  // single-digit quotient table: value (0..99) over leading divisor magnitude (1..5)
  function automatic logic [3:0] quoLookup(input logic [6:0] v, input logic [2:0] d);
    logic [6:0] r;
    case (d)
      3'd1:    r = v;
      3'd2:    r = v / 7'd2;
      3'd3:    r = v / 7'd3;
      3'd4:    r = v / 7'd4;
      3'd5:    r = v / 7'd5;
      default: r = 7'd0;
    endcase
    return r[3:0];
  endfunction

endpackage

// File: rtl/vdiv_normalize.sv
// Folds signed per-position sums into decimal digits (carry/borrow upward),
// then returns sign and BCD magnitude.
module vdiv_normalize #(
  parameter int N  = 9,
  parameter int RW = 8
) (
  input  logic [N-1:0][RW-1:0] raw,
  output logic [N-1:0][3:0]    mag,
  output logic                 neg
);

  logic [N-1:0][3:0] lowDig;

  always_comb begin
    int carry;
    int acc;
    int q10;
    int x;
    int borrow;
    carry = 0;
    for (int i = 0; i < N; i++) begin
      acc = int'($signed(raw[i])) + carry;
      if (acc >= 0) q10 = acc / 10;
      else          q10 = -((9 - acc) / 10);
      lowDig[i] = 4'(acc - 10 * q10);
      carry = q10;
    end
    neg = (carry < 0);
    borrow = 0;
    for (int i = 0; i < N; i++) begin
      if (neg) begin
        x = 0 - int'(lowDig[i]) - borrow;
        if (x < 0) begin
          x = x + 10;
          borrow = 1;
        end else begin
          borrow = 0;
        end
      end else begin
        x = int'(lowDig[i]);
      end
      mag[i] = 4'(x);
    end
  end

endmodule

// File: rtl/vdiv_estimator.sv
// Leading-digit quotient estimate, step offset and remainder-vs-divisor compare.
module vdiv_estimator #(
  parameter int RD = 9,
  localparam int PW = $clog2(RD)
) (
  input  logic [RD-1:0][3:0] remMag,
  input  logic [RD-1:0][4:0] adjDig,
  input  logic [RD-1:0][3:0] orgDig,
  output logic               canStep,
  output logic               remGeD,
  output logic [3:0]         qAbs,
  output logic [PW-1:0]      shift
);

  always_comb begin
    logic [PW-1:0] topPos;
    logic [PW-1:0] remPos;
    logic          remNz;
    logic [3:0]    lead;
    logic [3:0]    lowDig;
    logic [2:0]    dMag;
    logic [6:0]    vLead;
    int            sInt;
    logic          ge;

    topPos = '0;
    for (int i = 0; i < RD; i++)
      if (adjDig[i] != 5'd0) topPos = PW'(i);
    dMag = 3'(-int'($signed(adjDig[topPos])));

    remPos = '0;
    remNz  = 1'b0;
    for (int i = 0; i < RD; i++)
      if (remMag[i] != 4'd0) begin
        remPos = PW'(i);
        remNz  = 1'b1;
      end
    lead   = remMag[remPos];
    lowDig = 4'd0;
    for (int i = 0; i < RD - 1; i++)
      if (i + 1 == int'(remPos)) lowDig = remMag[i];

    if (int'(lead) >= int'(dMag)) begin
      vLead = {3'd0, lead};
      sInt  = int'(remPos) - int'(topPos);
    end else begin
      vLead = 7'(10 * int'(lead) + int'(lowDig));
      sInt  = int'(remPos) - 1 - int'(topPos);
    end

    canStep = remNz && (sInt >= 0);
    qAbs    = vdiv_pkg::quoLookup(vLead, dMag);
    shift   = canStep ? PW'(sInt) : '0;

    ge = 1'b1;
    for (int i = 0; i < RD; i++) begin
      if (remMag[i] > orgDig[i])      ge = 1'b1;
      else if (remMag[i] < orgDig[i]) ge = 1'b0;
    end
    remGeD = ge;
  end

endmodule

// File: rtl/vdiv_datapath.sv
module vdiv_datapath #(
  parameter int DIGITS = 8,
  localparam int RD  = DIGITS + 1,
  localparam int PW  = $clog2(RD),
  localparam int RRW = 8,
  localparam int QRW = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  vdiv_pkg::vdivCtrl_t    ctrl,
  input  logic [4*DIGITS-1:0]    dividendBcd,
  input  logic [5*RD-1:0]        adjDivisor,
  input  logic [4*DIGITS-1:0]    origDivisorBcd,
  output logic                   canStep,
  output logic                   remNeg,
  output logic                   remGeD,
  output logic [4*DIGITS-1:0]    quotientBcd,
  output logic [4*DIGITS-1:0]    remainderBcd
);

  logic [RD-1:0][3:0]     remMag, quoMag, orgReg;
  logic [RD-1:0][4:0]     adjReg;
  logic [RD-1:0][RRW-1:0] remRaw;
  logic [RD-1:0][QRW-1:0] quoRaw;
  logic [RD-1:0][3:0]     remNext, quoNext;
  logic                   remNextNeg, quoNextNeg;
  logic [3:0]             qAbs;
  logic [PW-1:0]          shift;

  vdiv_estimator #(.RD(RD)) u_est (
    .remMag (remMag),
    .adjDig (adjReg),
    .orgDig (orgReg),
    .canStep(canStep),
    .remGeD (remGeD),
    .qAbs   (qAbs),
    .shift  (shift)
  );

  always_comb begin
    int qS;
    int shU;
    int idx;
    int mv;
    qS = ctrl.fix ? 1 : int'(qAbs);
    if (remNeg) qS = -qS;
    shU = ctrl.fix ? 0 : int'(shift);
    for (int i = 0; i < RD; i++) begin
      mv = int'(remMag[i]);
      if (remNeg) mv = -mv;
      idx = i - shU;
      if (idx >= 0) mv = mv + qS * int'($signed(adjReg[idx[PW-1:0]]));
      remRaw[i] = RRW'(mv);
      quoRaw[i] = QRW'(int'(quoMag[i]) + ((i == shU) ? qS : 0));
    end
  end

  vdiv_normalize #(.N(RD), .RW(RRW)) u_normRem (
    .raw(remRaw), .mag(remNext), .neg(remNextNeg)
  );

  vdiv_normalize #(.N(RD), .RW(QRW)) u_normQuo (
    .raw(quoRaw), .mag(quoNext), .neg(quoNextNeg)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remMag <= '0;
      remNeg <= 1'b0;
      quoMag <= '0;
      adjReg <= '0;
      orgReg <= '0;
    end else if (ctrl.load) begin
      remNeg <= 1'b0;
      quoMag <= '0;
      adjReg <= adjDivisor;
      for (int i = 0; i < RD; i++) begin
        remMag[i] <= (i < DIGITS) ? dividendBcd[4*i +: 4] : 4'd0;
        orgReg[i] <= (i < DIGITS) ? origDivisorBcd[4*i +: 4] : 4'd0;
      end
    end else if (ctrl.step) begin
      remMag <= remNext;
      remNeg <= remNextNeg;
      quoMag <= quoNext;
    end
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_out
    assign quotientBcd[4*g +: 4]  = quoMag[g];
    assign remainderBcd[4*g +: 4] = remMag[g];
  end

  // R4: every aligned step uses a quotient digit in 1..9
  assert_qdigit_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.step && !ctrl.fix) |-> (qAbs >= 4'd1 && qAbs <= 4'd9));

  // R5: stored remainder digits stay decimal after every update
  assert_rem_digits_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrl.step) |-> (remMag[0] <= 4'd9 && remMag[RD-1] <= 4'd9 && remMag[RD/2] <= 4'd9));

  // R7: the running quotient never goes negative
  assert_quo_nonneg_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.step |-> !quoNextNeg);

endmodule

// File: rtl/vdiv_control.sv
module vdiv_control (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                canStep,
  input  logic                remNeg,
  input  logic                remGeD,
  output vdiv_pkg::vdivCtrl_t ctrl,
  output logic                busy,
  output logic                done
);
  import vdiv_pkg::*;

  vdivState_t state, stateNext;

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    case (state)
      ST_IDLE, ST_DONE: if (start) begin
        ctrl.load = 1'b1;
        stateNext = ST_RUN;
      end
      ST_RUN: begin
        if (canStep) ctrl.step = 1'b1;
        else         stateNext = ST_FIX;
      end
      ST_FIX: begin
        if (remNeg || remGeD) begin
          ctrl.step = 1'b1;
          ctrl.fix  = 1'b1;
        end else begin
          stateNext = ST_DONE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == ST_RUN) || (state == ST_FIX);
  assign done = (state == ST_DONE);

  // R2: an accepted start makes the block busy in the next cycle
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && !done));

  // R9: results stay valid until a new start
  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  // R9: done and busy never overlap
  assert_done_busy_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));

  // R7: correction ends only with a remainder in range
  assert_fix_exit_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(done)) |-> (!remNeg && !remGeD));

endmodule

// File: rtl/vdiv_top.sv
module vdiv_top #(
  parameter int DIGITS = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [4*DIGITS-1:0]     dividendBcd,
  input  logic [5*(DIGITS+1)-1:0] adjDivisor,
  input  logic [4*DIGITS-1:0]     origDivisorBcd,
  output logic [4*DIGITS-1:0]     quotientBcd,
  output logic [4*DIGITS-1:0]     remainderBcd,
  output logic                    busy,
  output logic                    done
);

  vdiv_pkg::vdivCtrl_t ctrl;
  logic canStep, remNeg, remGeD;

  vdiv_control u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .canStep(canStep),
    .remNeg (remNeg),
    .remGeD (remGeD),
    .ctrl   (ctrl),
    .busy   (busy),
    .done   (done)
  );

  vdiv_datapath #(.DIGITS(DIGITS)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctrl          (ctrl),
    .dividendBcd   (dividendBcd),
    .adjDivisor    (adjDivisor),
    .origDivisorBcd(origDivisorBcd),
    .canStep       (canStep),
    .remNeg        (remNeg),
    .remGeD        (remGeD),
    .quotientBcd   (quotientBcd),
    .remainderBcd  (remainderBcd)
  );

endmodule

// File: tb/sim_vdiv_top.sv
`timescale 1ns/1ps
module sim_vdiv_top;
  localparam int DIGITS = 8;
  localparam int RD = DIGITS + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [4*DIGITS-1:0] dividendBcd = '0;
  logic [5*RD-1:0]     adjDivisor = '0;
  logic [4*DIGITS-1:0] origDivisorBcd = '0;
  logic [4*DIGITS-1:0] quotientBcd, remainderBcd;
  logic busy, done;

  always #2.5 clk = ~clk;

  vdiv_top #(.DIGITS(DIGITS)) u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .dividendBcd(dividendBcd), .adjDivisor(adjDivisor), .origDivisorBcd(origDivisorBcd),
    .quotientBcd(quotientBcd), .remainderBcd(remainderBcd), .busy(busy), .done(done)
  );

  typedef struct {
    longint q;
    longint r;
    string  tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  function automatic logic [4*DIGITS-1:0] toBcd(longint v);
    logic [4*DIGITS-1:0] o;
    for (int i = 0; i < DIGITS; i++) begin
      o[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return o;
  endfunction

  function automatic longint fromBcd(logic [4*DIGITS-1:0] b);
    longint v = 0;
    for (int i = DIGITS - 1; i >= 0; i--) v = v * 10 + longint'(b[4*i +: 4]);
    return v;
  endfunction

  // negated signed-digit form: digits > 5 become digit-10 with a carry up
  function automatic logic [5*RD-1:0] adjOf(longint dv);
    logic [5*RD-1:0] o;
    int c = 0;
    int x;
    for (int i = 0; i < RD; i++) begin
      x = int'(dv % 10) + c;
      dv = dv / 10;
      if (x > 5) begin
        x = x - 10;
        c = 1;
      end else begin
        c = 0;
      end
      o[5*i +: 5] = 5'(-x);
    end
    return o;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic putOperands(longint n, longint dv);
    dividendBcd    = toBcd(n);
    origDivisorBcd = toBcd(dv);
    adjDivisor     = adjOf(dv);
  endtask

  task automatic runDiv(longint n, longint dv, string tag);
    expItem_t it;
    it.q = n / dv;
    it.r = n % dv;
    it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    putOperands(n, dv);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !done, "R2", "busy after start", longint'({busy, done}), 2);
    while (expQ.size() != 0) @(negedge clk);
  endtask

  // monitor: pops an expected item on each rising done
  initial begin
    bit prevDone = 1'b0;
    expItem_t it;
    forever begin
      @(negedge clk);
      if (done && !prevDone) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R9", "unexpected done", 1, 0);
        end else begin
          it = expQ.pop_front();
          check(fromBcd(quotientBcd) == it.q, it.tag, "quotient", fromBcd(quotientBcd), it.q);
          check(fromBcd(remainderBcd) == it.r, it.tag, "remainder", fromBcd(remainderBcd), it.r);
        end
      end
      prevDone = done;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    longint n, dv, held;
    expItem_t it;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R1", "busy/done after reset", longint'({busy, done}), 0);
    check(quotientBcd == '0, "R1", "quotient after reset", fromBcd(quotientBcd), 0);
    check(remainderBcd == '0, "R1", "remainder after reset", fromBcd(remainderBcd), 0);

    runDiv(99999, 456, "R4");
    runDiv(99999999, 47483647, "R3");
    runDiv(99999999, 99999999, "R6");
    runDiv(12345678, 99999999, "R10");
    runDiv(0, 7, "R10");
    runDiv(3, 8, "R10");
    runDiv(99999999, 1, "R5");
    runDiv(99999999, 15, "R7");
    runDiv(87654321, 6, "R7");
    runDiv(98765432, 1555, "R7");
    runDiv(99999998, 45454545, "R7");
    runDiv(50000000, 9, "R5");

    // R9: start while busy is ignored, results then hold
    it.q = 77777777 / 123;
    it.r = 77777777 % 123;
    it.tag = "R9";
    expQ.push_back(it);
    @(negedge clk);
    putOperands(77777777, 123);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    putOperands(55, 2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
    held = fromBcd(quotientBcd);
    repeat (6) @(negedge clk);
    check(done == 1'b1, "R9", "done held", longint'(done), 1);
    check(fromBcd(quotientBcd) == held, "R9", "quotient held", fromBcd(quotientBcd), held);

    for (int k = 0; k < 400; k++) begin
      n  = longint'($urandom % 100000000);
      dv = longint'($urandom % (10 ** (1 + ($urandom % 8)))) + 1;
      if (dv > 99999999) dv = 99999999;
      runDiv(n, dv, "R8");
    end

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule